// File: doc/BRIEF.md
# Trinary-Compatible Remote Frame Encoder

This block turns a parallel address word and a parallel data word into a serial, pulse-width-coded frame. The frame can be decoded by receivers built for remote-control links that use three symbol types: one, zero and open. The input pins carry only two levels. Two configuration inputs therefore choose how a high or a low level on the data group and on the address group is translated into those three symbols. The settings at the receiving end must use the same interpretation.

A prescaler divides the system clock into symbol-timer ticks, and all output timing is counted in ticks. While the transmit request is held high, the encoder sends frames back to back. Each frame starts with a long low synchronisation gap and a one-tick marker pulse, followed by every address bit and then every data bit, lowest index first. The inputs are captured once at the start of each frame. Dropping the request never cuts a frame short.

The control state machine has four states. ST_IDLE holds the line low. ST_GAP counts the synchronisation low time. ST_MARK drives the marker pulse. ST_SYM walks the symbol slots. Its transitions are:
- START (ST_IDLE to ST_GAP, on a tick with the request high, which also captures the inputs);
- GAP_DONE (ST_GAP to ST_MARK, after the last gap tick);
- MARK_DONE (ST_MARK to ST_SYM, after one tick);
- NEXT_SYM (ST_SYM to ST_SYM, after the eighth tick of a symbol that is not the last);
- REPEAT (ST_SYM to ST_GAP, after the last symbol with the request still high, which also captures the inputs again);
- STOP (ST_SYM to ST_IDLE, after the last symbol with the request low).

Top module: `tfe_frame_encoder`

## Requirements
- R1: During reset, and whenever no frame is in progress, `line_o` is low.
- R2: A frame is a low gap of at least GAP_TICKS ticks, then a high marker of exactly one tick, then ADDR_W address symbols (bit 0 first), then DATA_W data symbols (bit 0 first).
- R3: Every symbol lasts 8 ticks and consists of two 4-tick halves. A short half is 1 tick high then 3 ticks low; a long half is 3 ticks high then 1 tick low. Zero is short+short, one is long+long, and open is short (first) + long (second).
- R4: With `data_cfg_i` high, a high data pin is sent as one and a low data pin as zero.
- R5: With `data_cfg_i` low, a high data pin is sent as one and a low data pin as open.
- R6: `addr_cfg_i` (bit 1, bit 0) maps each address pin as follows: 00 sends high as one and low as zero; 01 sends high as one and low as open; 10 sends high as open and low as zero; 11 sends high as one and low as zero.
- R7: While `tx_en_i` stays high, frames follow one another with no idle ticks beyond the GAP_TICKS gap.
- R8: Address, data and both configuration inputs are captured at the start of a frame. Changes made during the frame affect only the next frame.
- R9: If `tx_en_i` falls during a frame, that frame completes in full and `line_o` then stays low.
- R10: One tick lasts TICK_DIV clock cycles, and `line_o` changes only at tick boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit request; frames repeat while high |
| addr_i | input | ADDR_W | Address pins, two-level |
| data_i | input | DATA_W | Data pins, two-level |
| data_cfg_i | input | 1 | Data interpretation select (R4/R5) |
| addr_cfg_i | input | 2 | Address interpretation select (R6) |
| line_o | output | 1 | Serial coded output line |

## Verification
The assertions check the following on every cycle: the line level in the idle, gap and marker states; that the marker lasts one tick; that the symbol index stays in range; that the line moves only on tick boundaries; and that the captured symbol set stays frozen between frame starts. The symbol waveform shapes, the per-mode mappings for data and address, the exact back-to-back gap length, the capture of inputs at frame start and the graceful finish after the request falls can only be shown by the bench. The bench decodes whole frames from the line and compares them with frames it computes from the requirements.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

    // Symbol codes carried in the captured frame image
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_OPEN = 2'd2
    } sym_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_MARK,
        ST_SYM
    } fsm_t;

    localparam int HALF_TICKS = 4;
    localparam int SYM_TICKS  = 2 * HALF_TICKS;
    localparam int POS_W      = $clog2(SYM_TICKS);

    // Data group: high -> one; low -> zero or open
    function automatic sym_t map_data(input logic level, input logic zero_mode);
        if (level)
            return SYM_ONE;
        return zero_mode ? SYM_ZERO : SYM_OPEN;
    endfunction

    // Address group: mode selects meaning of each level
    function automatic sym_t map_addr(input logic level, input logic [1:0] mode);
        sym_t s;
        unique case (mode)
            2'b01:   s = level ? SYM_ONE  : SYM_OPEN;
            2'b10:   s = level ? SYM_OPEN : SYM_ZERO;
            default: s = level ? SYM_ONE  : SYM_ZERO;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tfe_tick_gen.sv
module tfe_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CNT_W = $clog2(DIV);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/tfe_symbol_map.sv
module tfe_symbol_map
    import tfe_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              data_i,
    input  logic                           data_cfg_i,
    input  logic [1:0]                     addr_cfg_i,
    output logic [2*(ADDR_W+DATA_W)-1:0]   syms_o
);
    genvar i;
    generate
        for (i = 0; i < ADDR_W; i++) begin : g_addr
            assign syms_o[2*i +: 2] = map_addr(addr_i[i], addr_cfg_i);
        end
        for (i = 0; i < DATA_W; i++) begin : g_data
            assign syms_o[2*(ADDR_W+i) +: 2] = map_data(data_i[i], data_cfg_i);
        end
    endgenerate
endmodule

// File: rtl/tfe_wave_gen.sv
module tfe_wave_gen
    import tfe_pkg::*;
(
    input  sym_t             sym_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             level_o
);
    localparam int HP_W = $clog2(HALF_TICKS);
    localparam logic [HP_W-1:0] HP_LAST = HP_W'(HALF_TICKS - 1);

    logic            second_half;
    logic [HP_W-1:0] half_pos;
    logic            long_half;

    assign second_half = pos_i[POS_W-1];
    assign half_pos    = pos_i[HP_W-1:0];

    always_comb begin
        unique case (sym_i)
            SYM_ONE:  long_half = 1'b1;
            SYM_OPEN: long_half = second_half;
            default:  long_half = 1'b0;
        endcase
    end

    // First tick always high, last tick always low, middle depends on length
    always_comb begin
        if (half_pos == '0)
            level_o = 1'b1;
        else if (half_pos == HP_LAST)
            level_o = 1'b0;
        else
            level_o = long_half;
    end
endmodule

// File: rtl/tfe_frame_encoder.sv
module tfe_frame_encoder
    import tfe_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int TICK_DIV  = 4,
    parameter int GAP_TICKS = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              data_cfg_i,
    input  logic [1:0]        addr_cfg_i,
    output logic              line_o
);
    localparam int NSYM     = ADDR_W + DATA_W;
    localparam int SYM_BITS = 2 * NSYM;
    localparam int IDX_W    = $clog2(NSYM);
    localparam int GAP_W    = $clog2(GAP_TICKS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NSYM - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TICKS - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SYM_TICKS - 1);

    logic                tick;
    logic [SYM_BITS-1:0] syms_live;
    logic [SYM_BITS-1:0] syms_q;
    fsm_t                state_q, state_d;
    logic [GAP_W-1:0]    gap_q, gap_d;
    logic [IDX_W-1:0]    idx_q, idx_d;
    logic [POS_W-1:0]    pos_q, pos_d;
    logic                load;
    logic                last_slot;
    sym_t                cur_sym;
    logic                wave;

    tfe_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tfe_symbol_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
        .addr_i     (addr_i),
        .data_i     (data_i),
        .data_cfg_i (data_cfg_i),
        .addr_cfg_i (addr_cfg_i),
        .syms_o     (syms_live)
    );

    assign cur_sym = sym_t'(syms_q[2*int'(idx_q) +: 2]);

    tfe_wave_gen u_wave (
        .sym_i   (cur_sym),
        .pos_i   (pos_q),
        .level_o (wave)
    );

    assign last_slot = (idx_q == IDX_LAST) && (pos_q == POS_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        idx_d   = idx_q;
        pos_d   = pos_q;
        load    = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tx_en_i) begin          // START
                        state_d = ST_GAP;
                        gap_d   = '0;
                        load    = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_LAST)      // GAP_DONE
                        state_d = ST_MARK;
                    else
                        gap_d = gap_q + 1'b1;
                end
                ST_MARK: begin                  // MARK_DONE
                    state_d = ST_SYM;
                    idx_d   = '0;
                    pos_d   = '0;
                end
                ST_SYM: begin
                    if (last_slot) begin
                        if (tx_en_i) begin      // REPEAT
                            state_d = ST_GAP;
                            gap_d   = '0;
                            load    = 1'b1;
                        end else begin          // STOP
                            state_d = ST_IDLE;
                        end
                    end else if (pos_q == POS_LAST) begin  // NEXT_SYM
                        idx_d = idx_q + 1'b1;
                        pos_d = '0;
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
            idx_q   <= '0;
            pos_q   <= '0;
            syms_q  <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
            idx_q   <= idx_d;
            pos_q   <= pos_d;
            if (load)
                syms_q <= syms_live;
        end
    end

    // Output decode from registered state only
    always_comb begin
        unique case (state_q)
            ST_MARK: line_o = 1'b1;
            ST_SYM:  line_o = wave;
            default: line_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tfe_frame_checker.sv
module tfe_frame_checker
    import tfe_pkg::*;
#(
    parameter int NSYM = 18
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick,
    input logic                       line_o,
    input fsm_t                       state,
    input logic                       load,
    input logic [2*NSYM-1:0]          syms,
    input logic [$clog2(NSYM)-1:0]    sym_idx
);
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !line_o);                                  // R1

    AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> !line_o);                                   // R2

    AST_MARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK) |-> line_o);                                   // R2

    AST_MARK_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK && tick) |=> (state == ST_SYM));                // R2

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYM) |-> (int'(sym_idx) < NSYM));                    // R2

    AST_TICK_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> $past(tick));                       // R10

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !load) |=> $stable(syms));                   // R8
endmodule

bind tfe_frame_encoder tfe_frame_checker #(.NSYM(NSYM)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .line_o  (line_o),
    .state   (state_q),
    .load    (load),
    .syms    (syms_q),
    .sym_idx (idx_q)
);

// File: tb/sim_tfe_frame_encoder.sv
`timescale 1ns/1ps
module sim_tfe_frame_encoder;
    localparam int T    = 2;
    localparam int GAP  = 36;
    localparam int NS   = 18;
    localparam int NT   = NS * 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [9:0] addr = '0;
    logic [7:0] data = '0;
    logic       dcfg = 1'b1;
    logic [1:0] acfg = 2'b00;
    logic       line_o;

    logic [9:0] nxt_addr;
    logic [7:0] nxt_data;
    logic       nxt_dcfg;
    logic [1:0] nxt_acfg;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tfe_frame_encoder #(.ADDR_W(10), .DATA_W(8), .TICK_DIV(T), .GAP_TICKS(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .addr_i(addr), .data_i(data),
        .data_cfg_i(dcfg), .addr_cfg_i(acfg), .line_o(line_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Codes: zero=0, one=1, open=2; symbol i at bits [2i+1:2i]
    function automatic logic [35:0] exp_frame(input logic [9:0] a, input logic [7:0] d,
                                              input logic dc, input logic [1:0] ac);
        logic [35:0] f;
        for (int i = 0; i < 10; i++) begin
            case (ac)
                2'b01:   f[2*i +: 2] = a[i] ? 2'd1 : 2'd2;
                2'b10:   f[2*i +: 2] = a[i] ? 2'd2 : 2'd0;
                default: f[2*i +: 2] = a[i] ? 2'd1 : 2'd0;
            endcase
        end
        for (int i = 0; i < 8; i++)
            f[2*(10+i) +: 2] = d[i] ? 2'd1 : (dc ? 2'd0 : 2'd2);
        return f;
    endfunction

    // hook: 0 none, 1 load next inputs mid-frame, 2 drop request mid-frame
    task automatic capture_frame(input int hook, output logic [35:0] got,
                                 output int lowrun, output int jitter, output int badshape);
        int guard;
        logic tl [0:NT-1];
        logic first;
        logic [3:0] h0, h1;
        lowrun = 0; jitter = 0; badshape = 0; guard = 0; got = '0;
        @(negedge clk);
        while (line_o !== 1'b1 && guard < 3000) begin
            lowrun++; guard++;
            @(negedge clk);
        end
        if (guard >= 3000) begin
            chk(0, "R2", "no marker pulse seen", 0, 1);
            return;
        end
        for (int c = 1; c < T; c++) begin
            @(negedge clk);
            if (line_o !== 1'b1) jitter++;
        end
        for (int k = 0; k < NT; k++) begin
            first = 1'b0;
            for (int c = 0; c < T; c++) begin
                @(negedge clk);
                if (c == 0) first = line_o;
                else if (line_o !== first) jitter++;
                if (k == 40 && c == 0) begin
                    if (hook == 1) begin
                        addr = nxt_addr; data = nxt_data; dcfg = nxt_dcfg; acfg = nxt_acfg;
                    end else if (hook == 2) begin
                        tx_en = 1'b0;
                    end
                end
            end
            tl[k] = first;
        end
        for (int s = 0; s < NS; s++) begin
            h0 = {tl[8*s], tl[8*s+1], tl[8*s+2], tl[8*s+3]};
            h1 = {tl[8*s+4], tl[8*s+5], tl[8*s+6], tl[8*s+7]};
            if (h0 == 4'b1000 && h1 == 4'b1000)      got[2*s +: 2] = 2'd0;
            else if (h0 == 4'b1110 && h1 == 4'b1110) got[2*s +: 2] = 2'd1;
            else if (h0 == 4'b1000 && h1 == 4'b1110) got[2*s +: 2] = 2'd2;
            else begin
                got[2*s +: 2] = 2'd3;
                badshape++;
            end
        end
    endtask

    task automatic idle_check(input string req, input int clocks);
        int highs = 0;
        repeat (clocks) begin
            @(negedge clk);
            if (line_o !== 1'b0) highs++;
        end
        chk(highs == 0, req, "line high while idle (count)", highs, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(line_o === 1'b0, "R1", "line during reset", line_o, 0);
        rst_n = 1'b1;
        idle_check("R1", 200);
    endtask

    task automatic run_single(input logic [9:0] a, input logic [7:0] d, input logic dc,
                              input logic [1:0] ac, input string req);
        logic [35:0] got;
        int lowrun, jitter, bad;
        addr = a; data = d; dcfg = dc; acfg = ac;
        tx_en = 1'b1;
        capture_frame(2, got, lowrun, jitter, bad);
        chk(got == exp_frame(a, d, dc, ac), req, "frame symbols", got, exp_frame(a, d, dc, ac));
        chk(lowrun >= GAP * T, "R2", "sync gap clocks", lowrun, GAP * T);
        chk(bad == 0, "R3", "malformed symbols", bad, 0);
        chk(jitter == 0, "R10", "mid-tick changes", jitter, 0);
        idle_check("R9", 200);
    endtask

    task automatic t_back_to_back();
        logic [35:0] got;
        int lowrun, jitter, bad;
        addr = 10'h0F3; data = 8'h3C; dcfg = 1'b1; acfg = 2'b00;
        nxt_addr = 10'h30C; nxt_data = 8'hC3; nxt_dcfg = 1'b0; nxt_acfg = 2'b01;
        tx_en = 1'b1;
        capture_frame(1, got, lowrun, jitter, bad);
        chk(got == exp_frame(10'h0F3, 8'h3C, 1'b1, 2'b00), "R8", "frame with mid-frame change",
            got, exp_frame(10'h0F3, 8'h3C, 1'b1, 2'b00));
        capture_frame(0, got, lowrun, jitter, bad);
        chk(got == exp_frame(10'h30C, 8'hC3, 1'b0, 2'b01), "R8", "next frame uses new inputs",
            got, exp_frame(10'h30C, 8'hC3, 1'b0, 2'b01));
        chk(lowrun == GAP * T, "R7", "back-to-back gap clocks", lowrun, GAP * T);
        capture_frame(2, got, lowrun, jitter, bad);
        chk(got == exp_frame(10'h30C, 8'hC3, 1'b0, 2'b01), "R9", "frame after request drop",
            got, exp_frame(10'h30C, 8'hC3, 1'b0, 2'b01));
        chk(lowrun == GAP * T, "R7", "third frame gap clocks", lowrun, GAP * T);
        idle_check("R9", 300);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        run_single(10'h2D9, 8'hA5, 1'b1, 2'b00, "R4");
        run_single(10'h2D9, 8'hA5, 1'b0, 2'b00, "R5");
        run_single(10'h1B6, 8'h0F, 1'b1, 2'b01, "R6");
        run_single(10'h1B6, 8'hF0, 1'b0, 2'b10, "R6");
        run_single(10'h155, 8'h81, 1'b1, 2'b11, "R6");
        run_single(10'h3FF, 8'h00, 1'b0, 2'b10, "R3");
        t_back_to_back();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule